// File: doc/BRIEF.md
# LCD Controller Command Decoder

This block sits behind the host byte port of a dot-matrix LCD controller. Every byte strobed in with the data/command select low is taken as a command. The block decodes an irregular opcode map and keeps the controller's configuration registers. These cover display enable, first displayed line, RAM page, RAM column, segment direction, inverse video, all-pixels-on, bias choice, common scan direction, supply control, regulator ratio, contrast level and the indicator. Each register is exported as a plain output for the display engine and the analog section to use.

Bytes strobed with the select high are display-data accesses. The block stores no pixels. It advances the column counter that the pixel RAM would use. Two opcodes open a second phase, in which the next command-phase byte is taken as a parameter. A read-modify-write mode lets the host read and rewrite a run of bytes. In this mode reads do not move the column, and leaving the mode puts the column back where it was when the mode began. A status byte summarises the decoder's state.

The control sits in a three-state machine. ST_CMD decodes opcodes. ST_VOL_ARG waits for the contrast byte and ST_IND_ARG waits for the indicator mode byte. Transitions: ST_CMD→ST_VOL_ARG on opcode 81h, ST_CMD→ST_IND_ARG on ACh or ADh, and either argument state→ST_CMD on the next command-phase byte. Read-modify-write is a separate flag that is orthogonal to these states.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After rst_n is released, every output is zero except volume, which is 20h (so status reads 20h).
- R2: AEh clears disp_on and AFh sets it.
- R3: Bytes 40h–7Fh load start_line with bits [5:0]. Bytes B0h–BFh load page with bits [3:0].
- R4: 10h–1Fh replace the upper column nibble with bits [3:0]. 00h–0Fh replace the lower nibble. A result above the last column (NUM_COLS-1, default 131) is clamped to the last column.
- R5: In each of the pairs A0h/A1h (seg_rev), A2h/A3h (bias_sel), A4h/A5h (all_on) and A6h/A7h (inv_disp), bit 0 gives the new value. For C0h–CFh, bit 3 gives com_rev.
- R6: 28h–2Fh load pwr_ctl with bits [2:0]. 20h–27h load res_ratio with bits [2:0].
- R7: 81h causes the next command-phase byte to load volume with bits [5:0]. ACh/ADh set ind_on to bit 0 and cause the next command-phase byte to load ind_mode with bits [1:0]. That parameter byte is never decoded as an opcode. Data-phase bytes in between are handled as data.
- R8: Outside read-modify-write, each data write or data read raises the column by one. At the last column it stays.
- R9: E0h saves the column and sets rmw_active. While it is set, data reads leave the column alone and data writes still advance it. EEh clears rmw_active and restores the saved column. EEh outside the mode has no effect.
- R10: E2h returns every register except disp_on to its reset value and leaves read-modify-write without restoring. E3h, F0h–FFh and all unlisted opcodes change nothing.
- R11: status is {awaiting-parameter, seg_rev, not disp_on, rmw_active, 4'b0000}, with bit 7 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_wr | input | 1 | Host write strobe, one cycle per byte |
| byte_rd | input | 1 | Host display-data read strobe |
| is_data | input | 1 | 1: display data, 0: command |
| byte_in | input | 8 | Host byte |
| disp_on | output | 1 | Display enabled |
| start_line | output | 6 | RAM line shown on the first common |
| page | output | 4 | RAM page |
| column | output | 8 | RAM column counter |
| seg_rev | output | 1 | Segment order reversed |
| inv_disp | output | 1 | Inverse video |
| all_on | output | 1 | All pixels forced on |
| bias_sel | output | 1 | Bias choice |
| com_rev | output | 1 | Common scan reversed |
| pwr_ctl | output | 3 | Supply circuit enables |
| res_ratio | output | 3 | Regulator resistor ratio |
| volume | output | 6 | Contrast level |
| ind_on | output | 1 | Indicator enabled |
| ind_mode | output | 2 | Indicator blink mode |
| rmw_active | output | 1 | Read-modify-write in progress |
| status | output | 8 | Status byte |

## Verification
The hardest state to reach is a read-modify-write run that ends at the column saved on entry. That saved column must differ from the column reached by the reads and writes inside the run. The stimulus first sets a known column through both nibble commands, then enters the mode and mixes reads and writes. It checks the column after each access and again after EEh. A further sequence places a data write between a two-byte opcode and its parameter, and then sends a valid opcode as the parameter. This exposes any decoder that treats the parameter as an opcode.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    typedef enum logic [1:0] {
        ST_CMD,
        ST_VOL_ARG,
        ST_IND_ARG
    } dec_state_e;

    typedef enum logic [4:0] {
        OP_NONE,
        OP_DISP,
        OP_START,
        OP_PAGE,
        OP_COL_HI,
        OP_COL_LO,
        OP_SEG,
        OP_INV,
        OP_ALLON,
        OP_BIAS,
        OP_RMW_ON,
        OP_RMW_OFF,
        OP_RESET,
        OP_COM,
        OP_PWR,
        OP_RATIO,
        OP_VOL,
        OP_IND
    } op_kind_e;

    typedef struct packed {
        logic       disp_on;
        logic [5:0] start_line;
        logic [3:0] page;
        logic       seg_rev;
        logic       inv_disp;
        logic       all_on;
        logic       bias_sel;
        logic       com_rev;
        logic [2:0] pwr_ctl;
        logic [2:0] res_ratio;
        logic [5:0] volume;
        logic       ind_on;
        logic [1:0] ind_mode;
    } cfg_regs_t;

endpackage

// File: rtl/lcd_op_classify.sv
module lcd_op_classify
    import lcd_cmd_pkg::*;
(
    input  logic [7:0] byte_in,
    output op_kind_e   op
);
    always_comb begin
        op = OP_NONE;
        casez (byte_in)
            8'b0000_????: op = OP_COL_LO;
            8'b0001_????: op = OP_COL_HI;
            8'b0010_0???: op = OP_RATIO;
            8'b0010_1???: op = OP_PWR;
            8'b01??_????: op = OP_START;
            8'h81:        op = OP_VOL;
            8'b1010_000?: op = OP_SEG;
            8'b1010_001?: op = OP_BIAS;
            8'b1010_010?: op = OP_ALLON;
            8'b1010_011?: op = OP_INV;
            8'b1010_110?: op = OP_IND;
            8'b1010_111?: op = OP_DISP;
            8'b1011_????: op = OP_PAGE;
            8'b1100_????: op = OP_COM;
            8'hE0:        op = OP_RMW_ON;
            8'hE2:        op = OP_RESET;
            8'hEE:        op = OP_RMW_OFF;
            default:      op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/lcd_col_ctr.sv
module lcd_col_ctr #(
    parameter int NUM_COLS = 132
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       restore,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       inc,
    input  logic       save,
    output logic [7:0] col
);
    localparam logic [7:0] LAST_COL = 8'(NUM_COLS - 1);

    logic [7:0] col_q;
    logic [7:0] saved_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q   <= '0;
            saved_q <= '0;
        end else if (clear) begin
            col_q   <= '0;
            saved_q <= '0;
        end else begin
            if (restore) begin
                col_q <= saved_q;
            end else if (load) begin
                col_q <= (load_val > LAST_COL) ? LAST_COL : load_val;
            end else if (inc && (col_q != LAST_COL)) begin
                col_q <= col_q + 8'd1;
            end
            if (save) begin
                saved_q <= col_q;
            end
        end
    end

    assign col = col_q;
endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
    import lcd_cmd_pkg::*;
#(
    parameter int         NUM_COLS    = 132,
    parameter logic [5:0] VOL_DEFAULT = 6'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_wr,
    input  logic       byte_rd,
    input  logic       is_data,
    input  logic [7:0] byte_in,
    output logic       disp_on,
    output logic [5:0] start_line,
    output logic [3:0] page,
    output logic [7:0] column,
    output logic       seg_rev,
    output logic       inv_disp,
    output logic       all_on,
    output logic       bias_sel,
    output logic       com_rev,
    output logic [2:0] pwr_ctl,
    output logic [2:0] res_ratio,
    output logic [5:0] volume,
    output logic       ind_on,
    output logic [1:0] ind_mode,
    output logic       rmw_active,
    output logic [7:0] status
);
    localparam cfg_regs_t CFG_RESET = '{
        disp_on:    1'b0,
        start_line: 6'd0,
        page:       4'd0,
        seg_rev:    1'b0,
        inv_disp:   1'b0,
        all_on:     1'b0,
        bias_sel:   1'b0,
        com_rev:    1'b0,
        pwr_ctl:    3'd0,
        res_ratio:  3'd0,
        volume:     VOL_DEFAULT,
        ind_on:     1'b0,
        ind_mode:   2'd0
    };

    dec_state_e st_q, st_d;
    op_kind_e   op;
    cfg_regs_t  cfg_q, cfg_d;
    logic       rmw_q, rmw_d;
    logic       cmd_byte, cmd_fire, param_fire;
    logic [7:0] col;
    logic       col_load;
    logic [7:0] col_val;

    lcd_op_classify u_cls (
        .byte_in (byte_in),
        .op      (op)
    );

    assign cmd_byte   = byte_wr && !is_data;
    assign cmd_fire   = cmd_byte && (st_q == ST_CMD);
    assign param_fire = cmd_byte && (st_q != ST_CMD);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_CMD;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_CMD: begin
                if (cmd_fire && op == OP_VOL)      st_d = ST_VOL_ARG;
                else if (cmd_fire && op == OP_IND) st_d = ST_IND_ARG;
            end
            ST_VOL_ARG: if (cmd_byte) st_d = ST_CMD;
            ST_IND_ARG: if (cmd_byte) st_d = ST_CMD;
            default:    st_d = ST_CMD;
        endcase
    end

    // register updates
    always_comb begin
        cfg_d = cfg_q;
        rmw_d = rmw_q;
        if (param_fire) begin
            if (st_q == ST_VOL_ARG) cfg_d.volume   = byte_in[5:0];
            else                    cfg_d.ind_mode = byte_in[1:0];
        end else if (cmd_fire) begin
            unique case (op)
                OP_DISP:    cfg_d.disp_on    = byte_in[0];
                OP_START:   cfg_d.start_line = byte_in[5:0];
                OP_PAGE:    cfg_d.page       = byte_in[3:0];
                OP_SEG:     cfg_d.seg_rev    = byte_in[0];
                OP_INV:     cfg_d.inv_disp   = byte_in[0];
                OP_ALLON:   cfg_d.all_on     = byte_in[0];
                OP_BIAS:    cfg_d.bias_sel   = byte_in[0];
                OP_COM:     cfg_d.com_rev    = byte_in[3];
                OP_PWR:     cfg_d.pwr_ctl    = byte_in[2:0];
                OP_RATIO:   cfg_d.res_ratio  = byte_in[2:0];
                OP_IND:     cfg_d.ind_on     = byte_in[0];
                OP_RMW_ON:  rmw_d = 1'b1;
                OP_RMW_OFF: rmw_d = 1'b0;
                OP_RESET: begin
                    cfg_d         = CFG_RESET;
                    cfg_d.disp_on = cfg_q.disp_on;
                    rmw_d         = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
            rmw_q <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            rmw_q <= rmw_d;
        end
    end

    // column address path
    assign col_load = cmd_fire && (op == OP_COL_HI || op == OP_COL_LO);
    assign col_val  = (op == OP_COL_HI) ? {byte_in[3:0], col[3:0]}
                                        : {col[7:4], byte_in[3:0]};

    lcd_col_ctr #(.NUM_COLS(NUM_COLS)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cmd_fire && op == OP_RESET),
        .restore  (cmd_fire && op == OP_RMW_OFF && rmw_q),
        .load     (col_load),
        .load_val (col_val),
        .inc      (is_data && (byte_wr || (byte_rd && !rmw_q))),
        .save     (cmd_fire && op == OP_RMW_ON),
        .col      (col)
    );

    // outputs
    assign disp_on    = cfg_q.disp_on;
    assign start_line = cfg_q.start_line;
    assign page       = cfg_q.page;
    assign column     = col;
    assign seg_rev    = cfg_q.seg_rev;
    assign inv_disp   = cfg_q.inv_disp;
    assign all_on     = cfg_q.all_on;
    assign bias_sel   = cfg_q.bias_sel;
    assign com_rev    = cfg_q.com_rev;
    assign pwr_ctl    = cfg_q.pwr_ctl;
    assign res_ratio  = cfg_q.res_ratio;
    assign volume     = cfg_q.volume;
    assign ind_on     = cfg_q.ind_on;
    assign ind_mode   = cfg_q.ind_mode;
    assign rmw_active = rmw_q;
    assign status     = {(st_q != ST_CMD), cfg_q.seg_rev, !cfg_q.disp_on, rmw_q, 4'b0000};
endmodule

// File: rtl/lcd_cmd_decoder_chk.sv
module lcd_cmd_decoder_chk #(
    parameter int NUM_COLS = 132
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_wr,
    input logic       byte_rd,
    input logic       is_data,
    input logic [7:0] byte_in,
    input logic       disp_on,
    input logic [5:0] start_line,
    input logic [7:0] column,
    input logic [5:0] volume,
    input logic       rmw_active,
    input logic [7:0] status
);
    localparam logic [7:0] LAST_COL = 8'(NUM_COLS - 1);

    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        column <= LAST_COL); // R4

    AST_DATA_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && is_data && column != LAST_COL) |=> (column == 8'($past(column) + 8'd1))); // R8

    AST_DATA_WR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && is_data && column == LAST_COL) |=> (column == LAST_COL)); // R8

    AST_RMW_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_active && byte_rd && !byte_wr) |=> $stable(column)); // R9

    AST_PARAM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && !is_data && byte_in == 8'h81 && !status[7]) |=> status[7]); // R7

    AST_HIGH_OPS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_wr && !is_data && byte_in[7:4] == 4'hF && !status[7])
        |=> ($stable(disp_on) && $stable(start_line) && $stable(column) && $stable(volume))); // R10

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[3:0] == 4'b0000); // R11
endmodule

bind lcd_cmd_decoder lcd_cmd_decoder_chk #(.NUM_COLS(NUM_COLS)) u_chk (.*);

// File: tb/lcd_cmd_decoder_tb.sv
module lcd_cmd_decoder_tb;
    localparam int NUM_COLS = 132;
    localparam int LAST = NUM_COLS - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_wr = 1'b0, byte_rd = 1'b0, is_data = 1'b0;
    logic [7:0] byte_in = '0;
    logic disp_on, seg_rev, inv_disp, all_on, bias_sel, com_rev, ind_on, rmw_active;
    logic [5:0] start_line, volume;
    logic [3:0] page;
    logic [7:0] column, status;
    logic [2:0] pwr_ctl, res_ratio;
    logic [1:0] ind_mode;

    int checks = 0, fails = 0;

    // reference model state
    int m_disp, m_start, m_page, m_col, m_saved, m_seg, m_inv, m_all, m_bias, m_com;
    int m_pwr, m_ratio, m_vol, m_ind, m_mode, m_rmw, m_wait;

    always #2 clk = ~clk;

    lcd_cmd_decoder #(.NUM_COLS(NUM_COLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .byte_rd(byte_rd),
        .is_data(is_data), .byte_in(byte_in), .disp_on(disp_on),
        .start_line(start_line), .page(page), .column(column), .seg_rev(seg_rev),
        .inv_disp(inv_disp), .all_on(all_on), .bias_sel(bias_sel), .com_rev(com_rev),
        .pwr_ctl(pwr_ctl), .res_ratio(res_ratio), .volume(volume), .ind_on(ind_on),
        .ind_mode(ind_mode), .rmw_active(rmw_active), .status(status)
    );

    task automatic model_reset(input bit keep_disp);
        if (!keep_disp) m_disp = 0;
        m_start = 0; m_page = 0; m_col = 0; m_saved = 0; m_seg = 0; m_inv = 0;
        m_all = 0; m_bias = 0; m_com = 0; m_pwr = 0; m_ratio = 0; m_vol = 32;
        m_ind = 0; m_mode = 0; m_rmw = 0; m_wait = 0;
    endtask

    function automatic int clampc(input int v);
        return (v > LAST) ? LAST : v;
    endfunction

    task automatic model_cmd(input int b);
        if (m_wait == 1) begin m_vol = b % 64; m_wait = 0; return; end
        if (m_wait == 2) begin m_mode = b % 4; m_wait = 0; return; end
        if (b < 16)                      m_col = clampc((m_col / 16) * 16 + b);
        else if (b < 32)                 m_col = clampc((b - 16) * 16 + m_col % 16);
        else if (b < 40)                 m_ratio = b - 32;
        else if (b < 48)                 m_pwr = b - 40;
        else if (b >= 64 && b < 128)     m_start = b - 64;
        else if (b == 129)               m_wait = 1;
        else if (b == 160 || b == 161)   m_seg = b - 160;
        else if (b == 162 || b == 163)   m_bias = b - 162;
        else if (b == 164 || b == 165)   m_all = b - 164;
        else if (b == 166 || b == 167)   m_inv = b - 166;
        else if (b == 172 || b == 173) begin m_ind = b - 172; m_wait = 2; end
        else if (b == 174 || b == 175)   m_disp = b - 174;
        else if (b >= 176 && b < 192)    m_page = b - 176;
        else if (b >= 192 && b < 208)    m_com = (b / 8) % 2;
        else if (b == 224) begin m_rmw = 1; m_saved = m_col; end
        else if (b == 226)               model_reset(1);
        else if (b == 238 && m_rmw == 1) begin m_rmw = 0; m_col = m_saved; end
    endtask

    task automatic model_data(input bit wr);
        if (wr || m_rmw == 0) m_col = (m_col >= LAST) ? LAST : m_col + 1;
    endtask

    function automatic logic [47:0] exp_vec();
        logic [7:0] st;
        st = {m_wait != 0, m_seg[0], ~m_disp[0], m_rmw[0], 4'b0000};
        return {m_disp[0], 6'(m_start), 4'(m_page), 8'(m_col), m_seg[0], m_inv[0],
                m_all[0], m_bias[0], m_com[0], 3'(m_pwr), 3'(m_ratio), 6'(m_vol),
                m_ind[0], 2'(m_mode), m_rmw[0], st};
    endfunction

    function automatic logic [47:0] act_vec();
        return {disp_on, start_line, page, column, seg_rev, inv_disp, all_on, bias_sel,
                com_rev, pwr_ctl, res_ratio, volume, ind_on, ind_mode, rmw_active, status};
    endfunction

    task automatic check(input string req);
        checks++;
        if (act_vec() !== exp_vec()) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act_vec(), exp_vec());
        end
    endtask

    task automatic send(input bit data, input int b);
        @(negedge clk);
        byte_wr = 1'b1; is_data = data; byte_in = 8'(b);
        @(negedge clk);
        byte_wr = 1'b0; is_data = 1'b0;
        if (data) model_data(1); else model_cmd(b);
    endtask

    task automatic read_data();
        @(negedge clk);
        byte_rd = 1'b1; is_data = 1'b1;
        @(negedge clk);
        byte_rd = 1'b0; is_data = 1'b0;
        model_data(0);
    endtask

    function automatic string req_of(input int b);
        if (b < 32) return "R4";
        if (b < 48) return "R6";
        if (b >= 64 && b < 128) return "R3";
        if (b == 129 || b == 172 || b == 173) return "R7";
        if (b >= 160 && b < 168) return "R5";
        if (b == 174 || b == 175) return "R2";
        if (b >= 176 && b < 192) return "R3";
        if (b >= 192 && b < 208) return "R5";
        if (b == 224 || b == 238) return "R9";
        return "R10";
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_reset(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // sweep of every opcode
        for (int b = 0; b < 256; b++) begin
            send(0, b);
            if (b == 129 || b == 172 || b == 173) begin
                check("R7 R11 busy");
                send(0, b ^ 8'h6B);
            end
            check(req_of(b));
        end

        // column nibbles and clamp
        send(0, 8'h1F); check("R4");
        send(0, 8'h0F); check("R4");
        send(0, 8'h10); send(0, 8'h05); check("R4");

        // saturating advance
        send(0, 8'h18); send(0, 8'h01); check("R4");
        for (int i = 0; i < 3; i++) begin send(1, 8'hA5); check("R8"); end
        send(0, 8'h10); send(0, 8'h0A);
        read_data(); check("R8 read");

        // read-modify-write
        send(0, 8'h12); send(0, 8'h00);
        send(0, 8'hE0); check("R9 R11");
        read_data(); check("R9");
        read_data(); check("R9");
        for (int i = 0; i < 3; i++) begin send(1, 8'h3C); check("R9"); end
        send(0, 8'hEE); check("R9");
        send(0, 8'hEE); check("R9 idle");

        // parameter consumption
        send(0, 8'hAF); check("R2");
        send(0, 8'h81); send(0, 8'hAE); check("R7");
        send(0, 8'hAD); send(1, 8'h00); check("R7 data");
        send(0, 8'h03); check("R7");

        // ignored opcodes and soft reset
        send(0, 8'hA1); send(0, 8'h55);
        for (int b = 240; b < 256; b++) send(0, b);
        send(0, 8'hE3); send(0, 8'h90); check("R10");
        send(0, 8'hE0); send(0, 8'hE2); check("R10");

        // hardware reset again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; model_reset(0);
        @(negedge clk); check("R1");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule